// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Unit

This block couples two eight-line priority resolvers into one sixteen-line interrupt controller. Request lines 0 to 7 feed the master resolver. Lines 8 to 15 feed the slave resolver, at position `n & 7`. When the slave has a request that can be serviced, it posts an edge on master line 2. The master decides whether the processor interrupt line `int_o` is raised.

When the processor pulses `ack_i`, the unit takes the winning master line. If that line is 2, it also takes the winning slave line. In each resolver it takes one of two paths. In normal mode it marks the line in service. In auto-EOI mode it leaves the in-service state alone and can rotate the priority order. Edge-triggered requests are cleared by the acknowledge and level-triggered requests are kept. The vector byte is then latched on `vec_o`.

A per-line trigger-mode register chooses edge or level sensing. Some bits of it are fixed to edge and cannot be changed. The register is not cleared by `rst_ni`.

Top module: `cascade_ack_top`

## Requirements
- R1: A master line n (0..7) that wins yields `vec_o = {base_m_i, n[2:0]}`. A line whose `mask_i` bit is 1 never raises `int_o`, and clearing that mask bit lets the held request through.
- R2: A request on a master line raises `int_o` after one clock edge. A request on a slave line raises it after two edges: one edge for the slave, one for master line 2.
- R3: A slave request is forwarded to master line 2 as an edge. Acknowledging master line 2 also acknowledges the slave and yields `vec_o = {base_s_i, slave_line}`. A request still held on the slave after the acknowledge raises `int_o` again one edge later.
- R4: In normal mode (`aeoi_i` bit 0 for that resolver), the acknowledged line is marked in service. That line blocks itself and every line of lower priority. A line of higher priority still raises `int_o`.
- R5: In auto-EOI mode (`aeoi_i` bit 1), the acknowledge marks nothing in service. Lower-priority requests that are still pending keep `int_o` high.
- R6: With rotation enabled (`rot_aeoi_i` bit 1) in auto-EOI mode, the line after the acknowledged one, `(line + 1) & 7`, becomes highest priority. Priority falls in ascending line order from there, with wrap-around.
- R7: An acknowledge clears the request of an edge-triggered line. A level-triggered line keeps its request for as long as its input stays high.
- R8: A trigger-mode bit of 1 selects level sensing. Writes pass through a fixed mask: 0xF8 for the master (`trig_wdata_i[7:0]`) and 0xDE for the slave (`trig_wdata_i[15:8]`). Bits outside the mask stay edge-triggered.
- R9: The trigger-mode register keeps its contents through `rst_ni`.
- R10: An acknowledge with no serviceable master request yields `vec_o = {base_m_i, 3'd7}` and changes no resolver state.
- R11: When master line 2 wins but the slave has no serviceable request, `vec_o = {base_s_i, 3'd7}`.
- R12: After reset, `int_o` and `vec_o` are 0 and priority is fixed with line 0 highest. `vec_o` changes only on the edge that samples `ack_i`, and `int_o` reflects the updated state right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset (trigger register excluded) |
| irq_i | input | 16 | Request lines; 0..7 master, 8..15 slave |
| mask_i | input | 16 | Per-line mask, 1 = ignored |
| trig_we_i | input | 1 | Write strobe for the trigger-mode register |
| trig_wdata_i | input | 16 | Trigger-mode write data, 1 = level |
| aeoi_i | input | 2 | Auto-EOI enable; bit 0 master, bit 1 slave |
| rot_aeoi_i | input | 2 | Rotate on auto-EOI; bit 0 master, bit 1 slave |
| base_m_i | input | 5 | Master vector base (upper five vector bits) |
| base_s_i | input | 5 | Slave vector base (upper five vector bits) |
| ack_i | input | 1 | Acknowledge strobe, one cycle |
| int_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector latched at the last acknowledge |

## Verification
Every input is driven, and every output sampled, one nanosecond after a rising edge, so the latency is counted in edges.

A master request is checked on `int_o` after one edge. A slave request is checked low after one edge and high after the second, because it passes through master line 2. `vec_o` and the post-acknowledge `int_o` are checked right after the single edge on which `ack_i` was high.

The forwarded slave request is cleared at the acknowledge edge and is checked again one edge later. Priority order, the in-service blocking and the kept level requests are all checked through later vector values and `int_o`.

// File: rtl/cascade_ack_pkg.sv
`timescale 1ns/1ps
package cascade_ack_pkg;
  localparam int unsigned LINES_DEF = 8;
  localparam int unsigned CASC_LINE = 2;
  localparam logic [7:0]  M_TRIG_MASK_DEF = 8'hF8;
  localparam logic [7:0]  S_TRIG_MASK_DEF = 8'hDE;
endpackage

// File: rtl/cascade_ack_prio.sv
`timescale 1ns/1ps
// Finds the request nearest to the rotation offset; pos_o is the relative rank.
module cascade_ack_prio #(
  parameter int unsigned LINES = 8,
  localparam int unsigned LW = $clog2(LINES)
) (
  input  logic [LINES-1:0] req_i,
  input  logic [LW-1:0]    off_i,
  output logic             any_o,
  output logic [LW-1:0]    pos_o
);
  logic [LW-1:0] idx;

  always_comb begin
    any_o = |req_i;
    pos_o = '0;
    idx   = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      idx = LW'(i) + off_i;
      if (req_i[idx]) pos_o = LW'(i);
    end
  end
endmodule

// File: rtl/cascade_ack_slice.sv
`timescale 1ns/1ps
module cascade_ack_slice #(
  parameter int unsigned LINES = 8,
  localparam int unsigned LW = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] lvl_i,
  input  logic [LINES-1:0] push_i,
  input  logic [LINES-1:0] mask_i,
  input  logic [LINES-1:0] trig_i,
  input  logic             aeoi_i,
  input  logic             rot_i,
  input  logic             ack_i,
  output logic             pend_o,
  output logic [LW-1:0]    line_o
);
  logic [LINES-1:0] irr_q, irr_n, last_q, isr_q, isr_n;
  logic [LW-1:0]    off_q, off_n;
  logic             r_any, s_any;
  logic [LW-1:0]    r_pos, s_pos;

  cascade_ack_prio #(.LINES(LINES)) u_req (
    .req_i(irr_q & ~mask_i), .off_i(off_q), .any_o(r_any), .pos_o(r_pos));
  cascade_ack_prio #(.LINES(LINES)) u_svc (
    .req_i(isr_q), .off_i(off_q), .any_o(s_any), .pos_o(s_pos));

  // a line in service blocks equal and lower ranks
  assign pend_o = r_any && (!s_any || (r_pos < s_pos));
  assign line_o = r_pos + off_q;

  always_comb begin
    irr_n = irr_q;
    isr_n = isr_q;
    off_n = off_q;
    if (ack_i && pend_o) begin
      if (aeoi_i) begin
        if (rot_i) off_n = line_o + LW'(1);
      end else begin
        isr_n[line_o] = 1'b1;
      end
      if (!trig_i[line_o]) irr_n[line_o] = 1'b0;
    end
    for (int i = 0; i < LINES; i++) begin
      if (trig_i[i])                  irr_n[i] = lvl_i[i];
      else if (lvl_i[i] && !last_q[i]) irr_n[i] = 1'b1;
    end
    irr_n = irr_n | push_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q  <= '0;
      last_q <= '0;
      isr_q  <= '0;
      off_q  <= '0;
    end else begin
      irr_q  <= irr_n;
      last_q <= lvl_i;
      isr_q  <= isr_n;
      off_q  <= off_n;
    end
  end
endmodule

// File: rtl/cascade_ack_top.sv
`timescale 1ns/1ps
module cascade_ack_top
  import cascade_ack_pkg::*;
#(
  parameter int unsigned      LINES = LINES_DEF,
  parameter logic [LINES-1:0] M_TRIG_MASK = M_TRIG_MASK_DEF,
  parameter logic [LINES-1:0] S_TRIG_MASK = S_TRIG_MASK_DEF,
  localparam int unsigned     LW = $clog2(LINES),
  localparam int unsigned     NIRQ = 2 * LINES,
  localparam int unsigned     VEC_W = 8,
  localparam int unsigned     BASE_W = VEC_W - LW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NIRQ-1:0]   irq_i,
  input  logic [NIRQ-1:0]   mask_i,
  input  logic              trig_we_i,
  input  logic [NIRQ-1:0]   trig_wdata_i,
  input  logic [1:0]        aeoi_i,
  input  logic [1:0]        rot_aeoi_i,
  input  logic [BASE_W-1:0] base_m_i,
  input  logic [BASE_W-1:0] base_s_i,
  input  logic              ack_i,
  output logic              int_o,
  output logic [VEC_W-1:0]  vec_o
);
  localparam logic [LW-1:0] CASC = LW'(CASC_LINE);
  localparam logic [LW-1:0] SPUR = {LW{1'b1}};

  logic [NIRQ-1:0]  trig_q;
  logic [LINES-1:0] push_m;
  logic             m_pend, s_pend, ack_s;
  logic [LW-1:0]    m_line, s_line;
  logic [VEC_W-1:0] vec_d, vec_q;

  // trigger modes survive controller reset
  always_ff @(posedge clk_i) begin
    if (trig_we_i) trig_q <= trig_wdata_i & {S_TRIG_MASK, M_TRIG_MASK};
  end

  // slave pending pulses master cascade line; held off while it is acknowledged
  always_comb begin
    push_m       = '0;
    push_m[CASC] = s_pend & ~ack_i;
  end

  assign ack_s = ack_i & m_pend & (m_line == CASC);

  cascade_ack_slice #(.LINES(LINES)) u_master (
    .clk_i, .rst_ni,
    .lvl_i (irq_i[LINES-1:0]),
    .push_i(push_m),
    .mask_i(mask_i[LINES-1:0]),
    .trig_i(trig_q[LINES-1:0]),
    .aeoi_i(aeoi_i[0]),
    .rot_i (rot_aeoi_i[0]),
    .ack_i (ack_i),
    .pend_o(m_pend),
    .line_o(m_line)
  );

  cascade_ack_slice #(.LINES(LINES)) u_slave (
    .clk_i, .rst_ni,
    .lvl_i (irq_i[NIRQ-1:LINES]),
    .push_i('0),
    .mask_i(mask_i[NIRQ-1:LINES]),
    .trig_i(trig_q[NIRQ-1:LINES]),
    .aeoi_i(aeoi_i[1]),
    .rot_i (rot_aeoi_i[1]),
    .ack_i (ack_s),
    .pend_o(s_pend),
    .line_o(s_line)
  );

  always_comb begin
    if (!m_pend)             vec_d = {base_m_i, SPUR};
    else if (m_line != CASC) vec_d = {base_m_i, m_line};
    else if (s_pend)         vec_d = {base_s_i, s_line};
    else                     vec_d = {base_s_i, SPUR};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    vec_q <= '0;
    else if (ack_i) vec_q <= vec_d;
  end

  assign int_o = m_pend;
  assign vec_o = vec_q;
endmodule

// File: rtl/cascade_ack_chk.sv
`timescale 1ns/1ps
module cascade_ack_chk #(
  parameter int unsigned LW = 3,
  parameter int unsigned BASE_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ack_i,
  input logic              int_o,
  input logic [7:0]        vec_o,
  input logic [BASE_W-1:0] base_m_i,
  input logic [BASE_W-1:0] base_s_i,
  input logic [LW-1:0]     m_line
);
  assert_vec_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |=> $stable(vec_o));

  assert_spur_master_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !int_o) |=> (vec_o == {$past(base_m_i), 3'd7}));

  assert_master_vec_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && int_o && (m_line != 3'd2)) |=> (vec_o == {$past(base_m_i), $past(m_line)}));

  assert_slave_vec_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && int_o && (m_line == 3'd2)) |=> (vec_o[7:3] == $past(base_s_i)));
endmodule

bind cascade_ack_top cascade_ack_chk #(.LW(LW), .BASE_W(BASE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ack_i(ack_i), .int_o(int_o), .vec_o(vec_o),
  .base_m_i(base_m_i), .base_s_i(base_s_i), .m_line(m_line)
);

// File: tb/cascade_ack_top_test.sv
`timescale 1ns/1ps
module cascade_ack_top_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] irq, mask, trig_wd;
  logic        trig_we, ack;
  logic [1:0]  aeoi, rot;
  logic [4:0]  base_m, base_s;
  logic        int_o;
  logic [7:0]  vec;
  int          errors = 0;
  int          checks = 0;

  always #2.5 clk = ~clk;

  cascade_ack_top uut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .mask_i(mask),
    .trig_we_i(trig_we), .trig_wdata_i(trig_wd), .aeoi_i(aeoi), .rot_aeoi_i(rot),
    .base_m_i(base_m), .base_s_i(base_s), .ack_i(ack), .int_o(int_o), .vec_o(vec)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; irq = '0; mask = '0; ack = 1'b0; aeoi = '0; rot = '0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic write_trig(input logic [15:0] v);
    trig_we = 1'b1; trig_wd = v;
    tick();
    trig_we = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1;
    tick();
    ack = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R12 int after reset", {7'd0, int_o}, 8'h00);
    check("R12 vec after reset", vec, 8'h00);
  endtask

  task automatic t_master_nesting();
    do_reset();
    irq = 16'h0028;
    tick();
    check("R2 master latency", {7'd0, int_o}, 8'h01);
    do_ack();
    check("R12 fixed priority lowest wins", vec, 8'h23);
    check("R4 lower line blocked by service", {7'd0, int_o}, 8'h00);
    irq = 16'h002A;
    tick();
    check("R4 higher line raises int", {7'd0, int_o}, 8'h01);
    do_ack();
    check("R1 master vector", vec, 8'h21);
  endtask

  task automatic t_mask();
    do_reset();
    mask = 16'h0040; irq = 16'h0040;
    tick(); tick();
    check("R1 masked line ignored", {7'd0, int_o}, 8'h00);
    mask = 16'h0000;
    tick();
    check("R1 unmasked line raises", {7'd0, int_o}, 8'h01);
    do_ack();
    check("R1 vector line 6", vec, 8'h26);
  endtask

  task automatic t_slave();
    do_reset();
    irq = 16'h1000;
    tick();
    check("R2 slave not yet", {7'd0, int_o}, 8'h00);
    tick();
    check("R2 slave after two edges", {7'd0, int_o}, 8'h01);
    do_ack();
    check("R3 slave vector", vec, 8'h74);
    check("R4 cascade in service", {7'd0, int_o}, 8'h00);
    irq = 16'h1001;
    tick();
    check("R4 line 0 over cascade", {7'd0, int_o}, 8'h01);
    do_ack();
    check("R1 line 0 vector", vec, 8'h20);
  endtask

  task automatic t_rotate();
    do_reset();
    aeoi = 2'b01; rot = 2'b01;
    irq = 16'h0022;
    tick();
    do_ack();
    check("R5 aeoi first vector", vec, 8'h21);
    check("R5 no service, line 5 still raises", {7'd0, int_o}, 8'h01);
    do_ack();
    check("R5 second vector", vec, 8'h25);
    check("R7 edge lines cleared", {7'd0, int_o}, 8'h00);
    irq = 16'h00B2;
    tick();
    do_ack();
    check("R6 rotated order picks 7", vec, 8'h27);
    do_ack();
    check("R6 then 4", vec, 8'h24);
  endtask

  task automatic t_trig_mask();
    do_reset();
    write_trig(16'hFFFF);
    aeoi = 2'b11;
    irq = 16'h0001;
    tick();
    do_ack();
    check("R8 line 0 stays edge", vec, 8'h20);
    check("R8 line 0 cleared", {7'd0, int_o}, 8'h00);
    irq = 16'h0009;
    tick();
    do_ack();
    check("R7 level line vector", vec, 8'h23);
    check("R7 level request kept", {7'd0, int_o}, 8'h01);
    irq = 16'h0001;
    tick();
    check("R7 level follows input", {7'd0, int_o}, 8'h00);
    irq = 16'h0101;
    tick(); tick();
    do_ack();
    check("R8 slave line 8 edge", vec, 8'h70);
    tick();
    check("R8 slave line 8 cleared", {7'd0, int_o}, 8'h00);
    irq = 16'h0301;
    tick(); tick();
    do_ack();
    check("R3 slave level vector", vec, 8'h71);
    check("R3 cascade cleared at ack", {7'd0, int_o}, 8'h00);
    tick();
    check("R3 cascade reposted", {7'd0, int_o}, 8'h01);
  endtask

  task automatic t_retain();
    do_reset();
    aeoi = 2'b01;
    irq = 16'h0008;
    tick();
    do_ack();
    check("R9 level mode kept over reset", {7'd0, int_o}, 8'h01);
  endtask

  task automatic t_spur_master();
    do_reset();
    write_trig(16'h0020);
    irq = 16'h0020;
    tick();
    check("R10 level raised", {7'd0, int_o}, 8'h01);
    irq = 16'h0000;
    tick();
    do_ack();
    check("R10 spurious master vector", vec, 8'h27);
    irq = 16'h0040;
    tick();
    do_ack();
    check("R10 no state left by spurious", vec, 8'h26);
  endtask

  task automatic t_spur_slave();
    do_reset();
    write_trig(16'h0200);
    irq = 16'h0200;
    tick(); tick();
    irq = 16'h0000;
    tick();
    check("R11 cascade edge held", {7'd0, int_o}, 8'h01);
    do_ack();
    check("R11 spurious slave vector", vec, 8'h77);
  endtask

  initial begin
    rst_n = 1'b0; irq = '0; mask = '0; ack = 1'b0; aeoi = '0; rot = '0;
    base_m = 5'h04; base_s = 5'h0E;
    trig_we = 1'b1; trig_wd = '0;
    tick();
    trig_we = 1'b0;
    t_reset_state();
    t_master_nesting();
    t_mask();
    t_slave();
    t_rotate();
    t_trig_mask();
    t_retain();
    t_spur_master();
    t_spur_slave();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule